// File: doc/BRIEF.md
# UART Register Front End with Interrupt Identification

This block is the byte-wide, memory-mapped register side of a classic eight-register serial port. A bus master reaches it through an address, separate read and write strobes and 8-bit data buses. The block decodes the register offset, keeps the configuration bytes (interrupt enable, line control, modem control, FIFO control, scratch and the 16-bit baud divisor), and presents fixed line and modem status. On the character side it hands received bytes up from an rx-available flag and byte with a pop strobe, and pushes written bytes out with a push strobe. In loopback mode the byte goes to a separate loopback push instead.

Interrupts are level based. Every clock the block re-evaluates whether a receive-ready or transmit-ready condition is pending with its enable set. It publishes the result in the identification byte and drives one interrupt pin, gated by a modem-control output bit. The transmitter is modelled as always ready. Enabling the transmit interrupt from a disabled state marks a transmit-ready condition. Serial shifting, baud generation and real FIFOs sit outside this block.

Top module: `serial_reg_front`

## Requirements
- R1: The bus address is shifted right by ADDR_SHIFT (multiplier 2^ADDR_SHIFT) to give the register offset. An offset of 8 or more reads as 0x00, and a write to it changes no register and raises no strobe.
- R2: Line control bit 7 selects the divisor. While it is set, offset 0 reads and writes the divisor low byte and offset 1 the high byte, and no rx pop, tx push or loopback push is raised.
- R3: After reset the divisor is 12, line control is 0x03 (8 data bits, no parity, 1 stop), interrupt enable, modem control, FIFO control and scratch are 0x00, the identification byte reads 0x01 and irq is low.
- R4: With the divisor not selected, a read of offset 0 returns rx_byte and raises rx_pop. A write of offset 0 drives the byte out with tx_push, or with loop_push when modem control bit 4 (loopback) is set. Either write marks transmit-ready pending, which then stays set.
- R5: Line status (offset 5) reads bit 0 = rx_avail, bits 5 and 6 = 1 and all other bits 0. Writes to it are ignored.
- R6: Modem status (offset 6) always reads 0xB0 (carrier detect, data set ready and clear to send set). Writes to it are ignored.
- R7: The identification byte (offset 2 read) has bit 2 = rx_avail and bit 1 = transmit-ready pending. Bit 0 is 0 when (enable bit 0 and rx_avail) or (enable bit 1 and tx pending) held at the previous clock edge, else 1.
- R8: An interrupt enable write that sets bit 1 while bit 1 was clear marks transmit-ready pending.
- R9: irq is high exactly when a condition is pending (identification bit 0 low) and modem control bit 3 is set.
- R10: A write to offset 2 loads the FIFO control byte. With FIFO_EN set, identification bits 7:6 show FIFO control bits 2:1, and bits 5:3 read 0.
- R11: Offsets 3 (line control), 4 (modem control) and 7 (scratch) read back the full byte last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address into the register window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd |
| rx_avail | input | 1 | A received byte is waiting |
| rx_byte | input | 8 | Waiting received byte |
| rx_pop | output | 1 | Received byte consumed this cycle |
| tx_byte | output | 8 | Byte to transmit |
| tx_push | output | 1 | Transmit byte valid this cycle |
| loop_byte | output | 8 | Byte routed back to the receive path |
| loop_push | output | 1 | Loopback byte valid this cycle |
| irq | output | 1 | Level interrupt request |

## Verification
Read data and the rx_pop, tx_push and loop_push strobes are combinational, so they are due in the same cycle as the bus strobe. The bench samples strobes 1 ns after driving them and samples read data 2 ns after the clock edge that follows raising bus_rd. A register write takes effect at the first edge. The identification byte and irq reflect a new condition one edge after the condition has reached the registers, so a write followed by a read already covers that extra edge. A change of modem control bit 3 alone shows on irq right after its write edge, and the bench checks irq at that point.

// File: rtl/serial_reg_pkg.sv
// Shared offsets, bit positions and decode types for the serial register front end.
// Assumes an eight-byte register window.
package serial_reg_pkg;

    localparam int REG_COUNT = 8;
    localparam int OFF_W     = 3;
    localparam int DIV_W     = 16;

    typedef enum logic [OFF_W-1:0] {
        OFF_DATA    = 3'd0,
        OFF_IEN     = 3'd1,
        OFF_IDENT   = 3'd2,
        OFF_LINE    = 3'd3,
        OFF_MODEM   = 3'd4,
        OFF_LSTAT   = 3'd5,
        OFF_MSTAT   = 3'd6,
        OFF_SCRATCH = 3'd7
    } reg_off_e;

    // Bit positions that the interrupt and routing logic decode
    localparam int LINE_DIVSEL = 7;
    localparam int MODEM_OUT2  = 3;
    localparam int MODEM_LOOP  = 4;
    localparam int IEN_RX      = 0;
    localparam int IEN_TX      = 1;
    localparam int LSTAT_RXRDY = 0;
    localparam int LSTAT_THRE  = 5;
    localparam int LSTAT_TEMT  = 6;

    localparam logic [7:0] MSTAT_FIXED = 8'hB0;

    // One write enable per writable storage element
    typedef struct packed {
        logic data;
        logic div_lo;
        logic div_hi;
        logic ien;
        logic fctl;
        logic line;
        logic modem;
        logic scratch;
    } wr_sel_t;

endpackage

// File: rtl/serial_reg_decode.sv
// Address decoder: scales the bus address down by the address multiplier,
// flags out-of-window offsets and turns strobes into per-register selects,
// honouring divisor aliasing on offsets 0 and 1.
// Assumes ADDR_W is wide enough to hold the shifted offset range.
module serial_reg_decode
    import serial_reg_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int ADDR_SHIFT = 0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              divsel,
    output logic              hit,
    output reg_off_e          off,
    output wr_sel_t           wr_sel,
    output logic              data_rd
);

    logic [ADDR_W-1:0] off_full;

    // Scale the address and check it lies inside the window
    always_comb begin
        off_full = bus_addr >> ADDR_SHIFT;
        hit      = (off_full < ADDR_W'(REG_COUNT));
        off      = reg_off_e'(off_full[OFF_W-1:0]);
    end

    // Write selects, with divisor aliasing on offsets 0 and 1
    always_comb begin
        wr_sel = '0;
        if (bus_wr && hit) begin
            unique case (off)
                OFF_DATA:    if (divsel) wr_sel.div_lo = 1'b1; else wr_sel.data = 1'b1;
                OFF_IEN:     if (divsel) wr_sel.div_hi = 1'b1; else wr_sel.ien  = 1'b1;
                OFF_IDENT:   wr_sel.fctl    = 1'b1;
                OFF_LINE:    wr_sel.line    = 1'b1;
                OFF_MODEM:   wr_sel.modem   = 1'b1;
                OFF_SCRATCH: wr_sel.scratch = 1'b1;
                default:     wr_sel = '0;
            endcase
        end
    end

    // Data-register read consumes the received byte
    always_comb begin
        data_rd = bus_rd && hit && (off == OFF_DATA) && !divsel;
    end

endmodule

// File: rtl/serial_reg_ctrl.sv
// Configuration storage: interrupt enable, line control, modem control,
// FIFO control, scratch and the baud divisor, plus the sticky
// transmit-ready pending flag.
// Assumes selects from serial_reg_decode are already qualified by the window.
module serial_reg_ctrl
    import serial_reg_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RESET  = 16'd12,
    parameter logic [7:0]       LINE_RESET = 8'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_sel_t          wr_sel,
    input  logic [7:0]       wdata,
    output logic [7:0]       ien,
    output logic [7:0]       line,
    output logic [7:0]       modem,
    output logic [7:0]       fctl,
    output logic [7:0]       scratch,
    output logic [DIV_W-1:0] divisor,
    output logic             tx_pend
);

    logic tx_enable_edge;

    // Detect the tx enable bit going from clear to set
    always_comb begin
        tx_enable_edge = wr_sel.ien && wdata[IEN_TX] && !ien[IEN_TX];
    end

    // Byte registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien     <= 8'h00;
            line    <= LINE_RESET;
            modem   <= 8'h00;
            fctl    <= 8'h00;
            scratch <= 8'h00;
        end else begin
            if (wr_sel.ien)     ien     <= wdata;
            if (wr_sel.line)    line    <= wdata;
            if (wr_sel.modem)   modem   <= wdata;
            if (wr_sel.fctl)    fctl    <= wdata;
            if (wr_sel.scratch) scratch <= wdata;
        end
    end

    // Divisor bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divisor <= DIV_RESET;
        end else begin
            if (wr_sel.div_lo) divisor[7:0]       <= wdata;
            if (wr_sel.div_hi) divisor[DIV_W-1:8] <= wdata;
        end
    end

    // Sticky transmit-ready pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_pend <= 1'b0;
        end else if (wr_sel.data || tx_enable_edge) begin
            tx_pend <= 1'b1;
        end
    end

    // R8: enabling tx interrupts from clear marks tx pending at the next edge
    a_r8_tx_enable_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel.ien && wdata[IEN_TX] && !ien[IEN_TX]) |=> tx_pend);

    // R4: a data write marks tx pending, and the flag never clears outside reset
    a_r4_data_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel.data |=> tx_pend);
    a_r4_tx_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pend |=> tx_pend);

endmodule

// File: rtl/serial_reg_irq.sv
// Interrupt evaluation: re-computes the pending state each clock from the
// enables and sources, builds the identification byte and gates the
// interrupt pin with the modem-control output bit.
// Assumes rx_avail is synchronous to clk.
module serial_reg_irq
    import serial_reg_pkg::*;
#(
    parameter bit FIFO_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] ien,
    input  logic       rx_avail,
    input  logic       tx_pend,
    input  logic       out2,
    input  logic [7:0] fctl,
    output logic [7:0] ident,
    output logic       irq
);

    logic       pend_q;
    logic       rx_q;
    logic [1:0] fifo_bits;

    // Pick whether FIFO control shows in the top identification bits
    generate
        if (FIFO_EN) begin : g_fifo_on
            assign fifo_bits = fctl[2:1];
        end else begin : g_fifo_off
            assign fifo_bits = 2'b00;
        end
    endgenerate

    // Re-evaluate pending state every clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            rx_q   <= 1'b0;
        end else begin
            pend_q <= (ien[IEN_RX] && rx_avail) || (ien[IEN_TX] && tx_pend);
            rx_q   <= rx_avail;
        end
    end

    // Assemble the identification byte and the gated pin
    always_comb begin
        ident = {fifo_bits, 3'b000, rx_q, tx_pend, !pend_q};
        irq   = pend_q && out2;
    end

    // R7: an enabled receive condition clears the no-pending bit one edge later
    a_r7_rx_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[IEN_RX] && rx_avail) |=> !ident[0]);

    // R7: with no enabled source the no-pending bit is set one edge later
    a_r7_idle_nopend: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ien[IEN_RX] && rx_avail) && !(ien[IEN_TX] && tx_pend)) |=> ident[0]);

    // R9: a pending condition with the output bit held reaches the pin
    a_r9_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[IEN_RX] && rx_avail && out2) ##1 out2 |-> irq);

endmodule

// File: rtl/serial_reg_front.sv
// Top of the serial register front end: ties decode, storage and interrupt
// logic together, multiplexes read data and drives the character strobes.
// Assumes single-cycle bus strobes and a character side that accepts a push
// in any cycle.
module serial_reg_front
    import serial_reg_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int ADDR_SHIFT = 0,
    parameter bit FIFO_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_avail,
    input  logic [7:0]        rx_byte,
    output logic              rx_pop,
    output logic [7:0]        tx_byte,
    output logic              tx_push,
    output logic [7:0]        loop_byte,
    output logic              loop_push,
    output logic              irq
);

    logic             hit;
    reg_off_e         off;
    wr_sel_t          wr_sel;
    logic             data_rd;
    logic [7:0]       ien;
    logic [7:0]       line;
    logic [7:0]       modem;
    logic [7:0]       fctl;
    logic [7:0]       scratch;
    logic [DIV_W-1:0] divisor;
    logic             tx_pend;
    logic [7:0]       ident;
    logic [7:0]       lstat;
    logic             divsel;

    assign divsel = line[LINE_DIVSEL];

    serial_reg_decode #(
        .ADDR_W     (ADDR_W),
        .ADDR_SHIFT (ADDR_SHIFT)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .divsel   (divsel),
        .hit      (hit),
        .off      (off),
        .wr_sel   (wr_sel),
        .data_rd  (data_rd)
    );

    serial_reg_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wdata   (bus_wdata),
        .ien     (ien),
        .line    (line),
        .modem   (modem),
        .fctl    (fctl),
        .scratch (scratch),
        .divisor (divisor),
        .tx_pend (tx_pend)
    );

    serial_reg_irq #(
        .FIFO_EN (FIFO_EN)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ien      (ien),
        .rx_avail (rx_avail),
        .tx_pend  (tx_pend),
        .out2     (modem[MODEM_OUT2]),
        .fctl     (fctl),
        .ident    (ident),
        .irq      (irq)
    );

    // Line status: transmitter always idle, rx bit follows the source
    always_comb begin
        lstat              = 8'h00;
        lstat[LSTAT_RXRDY] = rx_avail;
        lstat[LSTAT_THRE]  = 1'b1;
        lstat[LSTAT_TEMT]  = 1'b1;
    end

    // Read multiplexer with divisor aliasing
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd && hit) begin
            unique case (off)
                OFF_DATA:    bus_rdata = divsel ? divisor[7:0] : rx_byte;
                OFF_IEN:     bus_rdata = divsel ? divisor[DIV_W-1:8] : ien;
                OFF_IDENT:   bus_rdata = ident;
                OFF_LINE:    bus_rdata = line;
                OFF_MODEM:   bus_rdata = modem;
                OFF_LSTAT:   bus_rdata = lstat;
                OFF_MSTAT:   bus_rdata = MSTAT_FIXED;
                OFF_SCRATCH: bus_rdata = scratch;
                default:     bus_rdata = 8'h00;
            endcase
        end
    end

    // Character-side strobes: transmit or loop back, and receive pop
    always_comb begin
        rx_pop    = data_rd;
        tx_byte   = bus_wdata;
        loop_byte = bus_wdata;
        tx_push   = wr_sel.data && !modem[MODEM_LOOP];
        loop_push = wr_sel.data &&  modem[MODEM_LOOP];
    end

    // R1: an offset outside the window reads as zero
    a_r1_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |-> (bus_rdata == 8'h00));

    // R1: an offset outside the window raises no character strobe
    a_r1_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> !(tx_push || loop_push || rx_pop));

    // R2: divisor selection silences all character strobes
    a_r2_divsel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        divsel |-> !(rx_pop || tx_push || loop_push));

    // R4: a written byte goes to exactly one destination
    a_r4_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_push, loop_push}));

endmodule

// File: tb/tb_serial_reg_front.sv
`timescale 1ns/1ps
module tb_serial_reg_front;

    localparam int AW = 8;
    localparam int SH = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic          rx_avail = 1'b0;
    logic [7:0]    rx_byte = 8'h5A;
    logic          rx_pop;
    logic [7:0]    tx_byte;
    logic          tx_push;
    logic [7:0]    loop_byte;
    logic          loop_push;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] rd_val;
    logic       pop_s, txp_s, lpp_s;
    logic [7:0] txb_s, lpb_s;

    always #5 clk = ~clk;

    serial_reg_front #(.ADDR_W(AW), .ADDR_SHIFT(SH), .FIFO_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_avail(rx_avail), .rx_byte(rx_byte), .rx_pop(rx_pop),
        .tx_byte(tx_byte), .tx_push(tx_push), .loop_byte(loop_byte),
        .loop_push(loop_push), .irq(irq)
    );

    typedef struct packed {
        logic       wr;
        logic [3:0] off;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 4'd3, 8'h00, 8'h03, 4'd3},   // R3 line control reset
        '{1'b0, 4'd2, 8'h00, 8'h01, 4'd3},   // R3 identification reset
        '{1'b0, 4'd1, 8'h00, 8'h00, 4'd3},   // R3 interrupt enable reset
        '{1'b0, 4'd6, 8'h00, 8'hB0, 4'd6},   // R6 modem status fixed
        '{1'b0, 4'd5, 8'h00, 8'h60, 4'd5},   // R5 line status idle
        '{1'b1, 4'd7, 8'hA5, 8'h00, 4'd11},  // R11 scratch write
        '{1'b0, 4'd7, 8'h00, 8'hA5, 4'd11},  // R11 scratch read
        '{1'b1, 4'd3, 8'h83, 8'h00, 4'd2},   // R2 select divisor
        '{1'b0, 4'd0, 8'h00, 8'h0C, 4'd2},   // R2 divisor low reset 12
        '{1'b0, 4'd1, 8'h00, 8'h00, 4'd2},   // R2 divisor high reset
        '{1'b1, 4'd0, 8'h34, 8'h00, 4'd2},   // R2 divisor low write
        '{1'b1, 4'd1, 8'h12, 8'h00, 4'd2},   // R2 divisor high write
        '{1'b0, 4'd0, 8'h00, 8'h34, 4'd2},   // R2 divisor low read
        '{1'b0, 4'd1, 8'h00, 8'h12, 4'd2},   // R2 divisor high read
        '{1'b1, 4'd3, 8'h1B, 8'h00, 4'd11},  // R11 line control write
        '{1'b0, 4'd3, 8'h00, 8'h1B, 4'd11},  // R11 line control read
        '{1'b0, 4'd0, 8'h00, 8'h5A, 4'd4},   // R4 data read gives rx byte
        '{1'b1, 4'd5, 8'hFF, 8'h00, 4'd5},   // R5 line status write
        '{1'b0, 4'd5, 8'h00, 8'h60, 4'd5},   // R5 write ignored
        '{1'b1, 4'd2, 8'h06, 8'h00, 4'd10},  // R10 FIFO control write
        '{1'b0, 4'd2, 8'h00, 8'hC1, 4'd10}   // R10 bits 7:6 from FIFO control
    };

    function automatic logic [AW-1:0] adr(input int off);
        return AW'(off << SH);
    endfunction

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", what, act, exp);
        end
    endtask

    task automatic wr_at(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        #1;
        txp_s = tx_push; txb_s = tx_byte;
        lpp_s = loop_push; lpb_s = loop_byte;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_at(input logic [AW-1:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        pop_s = rx_pop;
        @(posedge clk);
        #2;
        rd_val = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr_at(adr(int'(VECS[i].off)), VECS[i].data);
            end else begin
                rd_at(adr(int'(VECS[i].off)));
                chk($sformatf("R%0d vector %0d", VECS[i].req, i), rd_val, VECS[i].exp);
            end
        end

        // R3: reset state of pin and identification
        do_reset();
        chk("R3 irq after reset", {7'd0, irq}, 8'h00);
        rd_at(adr(2));
        chk("R3 ident after reset", rd_val, 8'h01);

        // R7, R9, R5: receive interrupt path
        rx_avail = 1'b1;
        wr_at(adr(1), 8'h01);
        wr_at(adr(4), 8'h08);
        rd_at(adr(2));
        chk("R7 ident rx pending", rd_val, 8'h04);
        chk("R9 irq with out2", {7'd0, irq}, 8'h01);
        rd_at(adr(5));
        chk("R5 line status rx bit", rd_val, 8'h61);
        wr_at(adr(4), 8'h00);
        chk("R9 irq gated by out2", {7'd0, irq}, 8'h00);
        rx_avail = 1'b0;
        @(posedge clk);
        rd_at(adr(2));
        chk("R7 ident idle", rd_val, 8'h01);

        // R8: tx enable from clear marks pending
        wr_at(adr(1), 8'h03);
        rd_at(adr(2));
        chk("R8 ident tx pending", rd_val, 8'h02);
        wr_at(adr(4), 8'h08);
        chk("R9 irq tx source", {7'd0, irq}, 8'h01);
        wr_at(adr(1), 8'h00);
        rd_at(adr(2));
        chk("R7 disabled keeps tx bit only", rd_val, 8'h03);
        chk("R9 irq drops when disabled", {7'd0, irq}, 8'h00);

        // R4: data read pops, data write pushes
        rx_avail = 1'b1;
        rx_byte  = 8'hC3;
        rd_at(adr(0));
        chk("R4 data read byte", rd_val, 8'hC3);
        chk("R4 data read pops", {7'd0, pop_s}, 8'h01);
        rx_avail = 1'b0;
        wr_at(adr(0), 8'h41);
        chk("R4 tx push", {7'd0, txp_s}, 8'h01);
        chk("R4 tx byte", txb_s, 8'h41);
        chk("R4 no loop push", {7'd0, lpp_s}, 8'h00);

        // R4: loopback routing
        wr_at(adr(4), 8'h10);
        wr_at(adr(0), 8'h77);
        chk("R4 loop push", {7'd0, lpp_s}, 8'h01);
        chk("R4 loop byte", lpb_s, 8'h77);
        chk("R4 loop suppresses tx", {7'd0, txp_s}, 8'h00);
        rd_at(adr(4));
        chk("R11 modem control read", rd_val, 8'h10);

        // R2: divisor selected silences strobes
        wr_at(adr(4), 8'h00);
        wr_at(adr(3), 8'h80);
        rx_avail = 1'b1;
        rd_at(adr(0));
        chk("R2 divisor low read", rd_val, 8'h0C);
        chk("R2 no pop on divisor", {7'd0, pop_s}, 8'h00);
        wr_at(adr(0), 8'h99);
        chk("R2 no tx push on divisor", {7'd0, txp_s}, 8'h00);
        rd_at(adr(0));
        chk("R2 divisor low rewritten", rd_val, 8'h99);
        rx_avail = 1'b0;
        wr_at(adr(3), 8'h03);

        // R1: window and address scaling
        wr_at(adr(7), 8'h3C);
        wr_at(AW'(8'h20), 8'hEE);
        chk("R1 outside write no tx push", {7'd0, txp_s}, 8'h00);
        chk("R1 outside write no loop push", {7'd0, lpp_s}, 8'h00);
        rd_at(AW'(8'h20));
        chk("R1 outside read zero", rd_val, 8'h00);
        rd_at(AW'(8'h1F));
        chk("R1 scratch via scaled address", rd_val, 8'h3C);
        rd_at(adr(3));
        chk("R1 outside write left line control", rd_val, 8'h03);

        // R6: modem status write ignored
        wr_at(adr(6), 8'h00);
        rd_at(adr(6));
        chk("R6 modem status after write", rd_val, 8'hB0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule